// File: doc/BRIEF.md
# Dual-Mode Call Stack Controller

This block saves and restores the program counter of a small nibble-oriented controller on subroutine calls and returns. A 4-bit configuration register, mapped at data address 0xF84, picks the code-space mode and the RAM bank that holds the stack. The narrow mode (the reset default) keeps a 14-bit program space, saves a four-nibble frame and confines the stack to bank 0. The wide mode uses a 15-bit program counter, saves a six-nibble frame and lets the stack live in any of four banks.

A call request pushes the return address one nibble per cycle through a nibble-wide RAM write port, then loads the call target into the program counter. A return request reads the frame back one nibble per cycle through the same address port and reloads the program counter. Each accepted call also reports its machine-cycle cost, which depends on whether it is a long or a short call and on the mode. A register-relative branch is flagged as illegal while the narrow mode is active.

Top module: `dual_mode_callstack`

## Requirements
- R1: After reset the configuration register reads 4'b1000, the narrow mode is active (mode_wide = 0), the stack pointer is 0, busy is 0 and no RAM write is issued.
- R2: A write with address 12'hF84 stores data bits 3, 1 and 0 in the register; bit 2 always reads back 0. A write to any other address leaves the register unchanged.
- R3: Register bit 3 selects the mode: 1 gives the narrow mode, 0 gives the wide mode, shown on mode_wide.
- R4: In the wide mode register bits 1:0 appear as ram_addr[9:8] for every stack access; in the narrow mode ram_addr[9:8] is 2'b00 whatever those bits hold.
- R5: A call writes the return address as a frame of 4 nibbles (narrow, 14 address bits, upper bits zero) or 6 nibbles (wide, 15 address bits, upper bits zero), most significant nibble first, one per cycle; before each write the stack pointer is decremented and ram_addr[7:0] equals the new pointer.
- R6: After the last push of a call, pc_load pulses for one cycle with pc_out equal to the call target; in the narrow mode bit 14 of pc_out is 0, in the wide mode it is taken from the target.
- R7: A return reads the frame least significant nibble first at ram_addr[7:0] = stack pointer, incrementing the pointer after each read; one cycle after the last read pc_load pulses with the reassembled return address, bit 14 cleared in the narrow mode.
- R8: In the cycle after a call is accepted call_cycles shows 3 for a long call and 2 for a short call in the narrow mode, 4 and 3 in the wide mode.
- R9: A register-relative branch request raises illegal_branch in the next cycle only in the narrow mode; in the wide mode illegal_branch stays 0.
- R10: Call and return requests that arrive while busy is 1 are ignored; if a call and a return are requested in the same idle cycle the call is performed.
- R11: A call accepted in the same cycle as a register write uses the register value held before that write; the written value governs the following requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwr_en | input | 1 | Data-space write strobe |
| dwr_addr | input | 12 | Data-space write address |
| dwr_data | input | 4 | Data-space write nibble |
| call_req | input | 1 | Call request (one cycle) |
| call_long | input | 1 | 1 = long call, 0 = short call |
| call_target | input | 15 | Call destination address |
| ret_pc | input | 15 | Return address to save on a call |
| ret_req | input | 1 | Return request (one cycle) |
| rel_branch | input | 1 | Register-relative branch is being executed |
| ram_rdata | input | 4 | Stack RAM read data, valid for the current ram_addr |
| stk_cfg | output | 4 | Configuration register contents |
| mode_wide | output | 1 | 1 = wide program-space mode |
| sp_value | output | 8 | Stack pointer |
| busy | output | 1 | Push or pop sequence in progress |
| ram_we | output | 1 | Stack RAM write enable |
| ram_addr | output | 10 | Stack RAM address {bank, pointer} |
| ram_wdata | output | 4 | Stack RAM write nibble |
| pc_load | output | 1 | One-cycle strobe: load pc_out into the program counter |
| pc_out | output | 15 | New program counter value |
| call_cycles | output | 3 | Machine cycles of the last accepted call |
| illegal_branch | output | 1 | Register-relative branch flagged in narrow mode |

## Verification
The one real same-cycle collision is a register write landing on the edge at which a call is accepted: the call must freeze the old mode and bank while the register takes the new value. The bench provokes this by raising dwr_en and call_req in the same cycle, flipping the mode from wide to narrow, and judges it by the scoreboard seeing six nibble writes in the old bank and a call cost of the wide mode, while stk_cfg and mode_wide already show the new value. A second collision, call and return requested together, is judged by seeing only the push sequence.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PC_W       = 15;
    localparam int NIB_W      = 4;
    localparam int SP_W       = 8;
    localparam int BANK_W     = 2;
    localparam int DADDR_W    = 12;
    localparam logic [DADDR_W-1:0] CFG_ADDR = 12'hF84;
    localparam int NARROW_NIBS = 4;
    localparam int WIDE_NIBS   = 6;
    localparam int CYC_W       = 3;
    localparam int LONG_BASE   = 3;
    localparam int SHORT_BASE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/csc_cfg_reg.sv
module csc_cfg_reg #(
    parameter int DADDR_W = csc_pkg::DADDR_W,
    parameter logic [DADDR_W-1:0] CFG_ADDR = csc_pkg::CFG_ADDR,
    parameter int BANK_W = csc_pkg::BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DADDR_W-1:0] wr_addr,
    input  logic [3:0]         wr_data,
    input  logic               rel_branch,
    output logic [3:0]         cfg,
    output logic               mode_wide,
    output logic [BANK_W-1:0]  bank_eff,
    output logic               illegal
);
    localparam logic [3:0] CFG_RESET = 4'b1000;
    localparam logic [3:0] CFG_MASK  = 4'b1011;

    typedef struct packed {
        logic [3:0] cfg;
        logic       illegal;
    } cfg_s;

    cfg_s s_d, s_q;
    logic wr_hit;

    always_comb begin
        s_d     = s_q;
        wr_hit  = wr_en && (wr_addr == CFG_ADDR);
        if (wr_hit) begin
            s_d.cfg = wr_data & CFG_MASK;
        end
        s_d.illegal = rel_branch && s_q.cfg[3];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cfg     <= CFG_RESET;
            s_q.illegal <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg       = s_q.cfg;
    assign mode_wide = ~s_q.cfg[3];
    assign bank_eff  = mode_wide ? s_q.cfg[BANK_W-1:0] : '0;
    assign illegal   = s_q.illegal;

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CFG_ADDR) |=> (cfg == {$past(wr_data[3]), 1'b0, $past(wr_data[1:0])})); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CFG_ADDR) |=> $stable(cfg)); // R2
    AST_ILLEGAL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_branch && !mode_wide) |=> illegal); // R9
    AST_ILLEGAL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_branch && mode_wide) |=> !illegal); // R9
endmodule

// File: rtl/csc_cycle_calc.sv
module csc_cycle_calc #(
    parameter int CYC_W      = csc_pkg::CYC_W,
    parameter int LONG_BASE  = csc_pkg::LONG_BASE,
    parameter int SHORT_BASE = csc_pkg::SHORT_BASE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_long,
    input  logic             wide,
    output logic [CYC_W-1:0] cycles
);
    localparam logic [CYC_W-1:0] LONG_C  = CYC_W'(LONG_BASE);
    localparam logic [CYC_W-1:0] SHORT_C = CYC_W'(SHORT_BASE);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } cyc_s;

    cyc_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.cyc = (is_long ? LONG_C : SHORT_C) + (wide ? CYC_W'(1) : CYC_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cycles = s_q.cyc;

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cycles >= SHORT_C && cycles <= LONG_C + CYC_W'(1))); // R8
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cycles)); // R8
endmodule

// File: rtl/csc_seq.sv
module csc_seq #(
    parameter int PC_W        = csc_pkg::PC_W,
    parameter int NIB_W       = csc_pkg::NIB_W,
    parameter int SP_W        = csc_pkg::SP_W,
    parameter int BANK_W      = csc_pkg::BANK_W,
    parameter int NARROW_NIBS = csc_pkg::NARROW_NIBS,
    parameter int WIDE_NIBS   = csc_pkg::WIDE_NIBS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     call_req,
    input  logic                     ret_req,
    input  logic [PC_W-1:0]          call_target,
    input  logic [PC_W-1:0]          ret_pc,
    input  logic                     mode_wide,
    input  logic [BANK_W-1:0]        bank_eff,
    input  logic [NIB_W-1:0]         ram_rdata,
    output logic                     busy,
    output logic                     accept_call,
    output logic                     ram_we,
    output logic [BANK_W+SP_W-1:0]   ram_addr,
    output logic [NIB_W-1:0]         ram_wdata,
    output logic                     pc_load,
    output logic [PC_W-1:0]          pc_out,
    output logic [SP_W-1:0]          sp_value
);
    import csc_pkg::*;

    localparam int FRAME_W = WIDE_NIBS * NIB_W;
    localparam int CNT_W   = $clog2(WIDE_NIBS);
    localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_NIBS - 1);
    localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_NIBS - 1);

    typedef struct packed {
        seq_st_e             st;
        logic [SP_W-1:0]     sp;
        logic [CNT_W-1:0]    cnt;
        logic                wide;
        logic [BANK_W-1:0]   bank;
        logic [FRAME_W-1:0]  frame;
        logic [PC_W-1:0]     tgt;
        logic                ld;
        logic [PC_W-1:0]     pc;
    } seq_s;

    seq_s s_d, s_q;

    // clear the top program-counter bit when the narrow mode is in force
    function automatic logic [PC_W-1:0] fold_pc(input logic [PC_W-1:0] v, input logic wide);
        logic [PC_W-1:0] r;
        r = v;
        if (!wide) r[PC_W-1] = 1'b0;
        return r;
    endfunction

    logic [CNT_W-1:0] last_idx;
    logic [SP_W-1:0]  sp_dec;
    int               nib_pos;

    always_comb begin
        s_d         = s_q;
        s_d.ld      = 1'b0;
        accept_call = 1'b0;
        ram_we      = 1'b0;
        ram_wdata   = '0;
        ram_addr    = {s_q.bank, s_q.sp};
        last_idx    = s_q.wide ? WIDE_LAST : NARROW_LAST;
        sp_dec      = s_q.sp - SP_W'(1);
        nib_pos     = int'(s_q.cnt) * NIB_W;
        unique case (s_q.st)
            ST_IDLE: begin
                if (call_req) begin
                    accept_call = 1'b1;
                    s_d.st    = ST_PUSH;
                    s_d.wide  = mode_wide;
                    s_d.bank  = bank_eff;
                    s_d.cnt   = mode_wide ? WIDE_LAST : NARROW_LAST;
                    s_d.frame = FRAME_W'(fold_pc(ret_pc, mode_wide));
                    s_d.tgt   = fold_pc(call_target, mode_wide);
                end else if (ret_req) begin
                    s_d.st    = ST_POP;
                    s_d.wide  = mode_wide;
                    s_d.bank  = bank_eff;
                    s_d.cnt   = '0;
                    s_d.frame = '0;
                end
            end
            ST_PUSH: begin
                ram_we    = 1'b1;
                ram_addr  = {s_q.bank, sp_dec};
                ram_wdata = s_q.frame[nib_pos +: NIB_W];
                s_d.sp    = sp_dec;
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                    s_d.ld = 1'b1;
                    s_d.pc = s_q.tgt;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_POP: begin
                s_d.frame[nib_pos +: NIB_W] = ram_rdata;
                s_d.sp = s_q.sp + SP_W'(1);
                if (s_q.cnt == last_idx) begin
                    s_d.st = ST_IDLE;
                    s_d.ld = 1'b1;
                    s_d.pc = fold_pc(s_d.frame[PC_W-1:0], s_q.wide);
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.sp    <= '0;
            s_q.cnt   <= '0;
            s_q.wide  <= 1'b0;
            s_q.bank  <= '0;
            s_q.frame <= '0;
            s_q.tgt   <= '0;
            s_q.ld    <= 1'b0;
            s_q.pc    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign pc_load  = s_q.ld;
    assign pc_out   = s_q.pc;
    assign sp_value = s_q.sp;

    AST_NARROW_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.wide) |-> (ram_addr[BANK_W+SP_W-1:SP_W] == '0)); // R4
    AST_SP_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp_value == $past(ram_addr[SP_W-1:0]))); // R5
    AST_PC_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !s_q.wide) |-> !pc_out[PC_W-1]); // R6
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R7
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept_call); // R10
endmodule

// File: rtl/dual_mode_callstack.sv
module dual_mode_callstack #(
    parameter int PC_W    = csc_pkg::PC_W,
    parameter int NIB_W   = csc_pkg::NIB_W,
    parameter int SP_W    = csc_pkg::SP_W,
    parameter int BANK_W  = csc_pkg::BANK_W,
    parameter int DADDR_W = csc_pkg::DADDR_W,
    parameter int CYC_W   = csc_pkg::CYC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dwr_en,
    input  logic [DADDR_W-1:0]     dwr_addr,
    input  logic [3:0]             dwr_data,
    input  logic                   call_req,
    input  logic                   call_long,
    input  logic [PC_W-1:0]        call_target,
    input  logic [PC_W-1:0]        ret_pc,
    input  logic                   ret_req,
    input  logic                   rel_branch,
    input  logic [NIB_W-1:0]       ram_rdata,
    output logic [3:0]             stk_cfg,
    output logic                   mode_wide,
    output logic [SP_W-1:0]        sp_value,
    output logic                   busy,
    output logic                   ram_we,
    output logic [BANK_W+SP_W-1:0] ram_addr,
    output logic [NIB_W-1:0]       ram_wdata,
    output logic                   pc_load,
    output logic [PC_W-1:0]        pc_out,
    output logic [CYC_W-1:0]       call_cycles,
    output logic                   illegal_branch
);
    logic [BANK_W-1:0] bank_eff;
    logic              accept_call;

    csc_cfg_reg #(
        .DADDR_W (DADDR_W),
        .BANK_W  (BANK_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (dwr_en),
        .wr_addr    (dwr_addr),
        .wr_data    (dwr_data),
        .rel_branch (rel_branch),
        .cfg        (stk_cfg),
        .mode_wide  (mode_wide),
        .bank_eff   (bank_eff),
        .illegal    (illegal_branch)
    );

    csc_seq #(
        .PC_W   (PC_W),
        .NIB_W  (NIB_W),
        .SP_W   (SP_W),
        .BANK_W (BANK_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .call_target (call_target),
        .ret_pc      (ret_pc),
        .mode_wide   (mode_wide),
        .bank_eff    (bank_eff),
        .ram_rdata   (ram_rdata),
        .busy        (busy),
        .accept_call (accept_call),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .pc_load     (pc_load),
        .pc_out      (pc_out),
        .sp_value    (sp_value)
    );

    csc_cycle_calc #(
        .CYC_W (CYC_W)
    ) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept_call),
        .is_long (call_long),
        .wide    (mode_wide),
        .cycles  (call_cycles)
    );
endmodule

// File: tb/sim_dual_mode_callstack.sv
`timescale 1ns/1ps
module sim_dual_mode_callstack;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        dwr_en = 0;
    logic [11:0] dwr_addr = 0;
    logic [3:0]  dwr_data = 0;
    logic        call_req = 0, call_long = 0, ret_req = 0, rel_branch = 0;
    logic [14:0] call_target = 0, ret_pc = 0;
    logic [3:0]  ram_rdata;
    logic [3:0]  stk_cfg;
    logic        mode_wide, busy, ram_we, pc_load, illegal_branch;
    logic [7:0]  sp_value;
    logic [9:0]  ram_addr;
    logic [3:0]  ram_wdata;
    logic [14:0] pc_out;
    logic [2:0]  call_cycles;

    dual_mode_callstack u0 (
        .clk(clk), .rst_n(rst_n), .dwr_en(dwr_en), .dwr_addr(dwr_addr), .dwr_data(dwr_data),
        .call_req(call_req), .call_long(call_long), .call_target(call_target), .ret_pc(ret_pc),
        .ret_req(ret_req), .rel_branch(rel_branch), .ram_rdata(ram_rdata), .stk_cfg(stk_cfg),
        .mode_wide(mode_wide), .sp_value(sp_value), .busy(busy), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .pc_load(pc_load), .pc_out(pc_out),
        .call_cycles(call_cycles), .illegal_branch(illegal_branch)
    );

    // stack RAM model, read is combinational
    logic [3:0] mem [0:1023];
    initial for (int i = 0; i < 1024; i++) mem[i] = 4'h0;
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
    assign ram_rdata = mem[ram_addr];

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { logic [9:0] a; logic [3:0] d; } wr_t;
    wr_t         wq[$];
    logic [14:0] pq[$];
    string       ptag[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we) begin
                if (wq.size() == 0) chk(0, "R10 unexpected stack write", {22'd0, ram_addr}, 0);
                else begin
                    wr_t e;
                    e = wq.pop_front();
                    chk(ram_addr == e.a, "R4/R5 write address", {22'd0, ram_addr}, {22'd0, e.a});
                    chk(ram_wdata == e.d, "R5 write nibble", {28'd0, ram_wdata}, {28'd0, e.d});
                end
            end
            if (pc_load) begin
                if (pq.size() == 0) chk(0, "R10 unexpected pc load", {17'd0, pc_out}, 0);
                else begin
                    logic [14:0] ep;
                    string t;
                    ep = pq.pop_front();
                    t = ptag.pop_front();
                    chk(pc_out == ep, t, {17'd0, pc_out}, {17'd0, ep});
                end
            end
        end
    end

    // bench model
    logic [3:0]  cfg_m;
    logic [7:0]  sp_m;
    logic [14:0] rs_pc[$];

    function automatic bit m_wide(); return !cfg_m[3]; endfunction
    function automatic logic [1:0] m_bank(); return m_wide() ? cfg_m[1:0] : 2'b00; endfunction

    task automatic wr_reg(input logic [11:0] a, input logic [3:0] d);
        @(negedge clk);
        dwr_en = 1; dwr_addr = a; dwr_data = d;
        @(negedge clk);
        dwr_en = 0;
        if (a == 12'hF84) cfg_m = {d[3], 1'b0, d[1:0]};
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_call(input logic [14:0] tgt, input logic [14:0] rpc, input bit lng,
                           input bit with_wr, input logic [3:0] wd, input bit with_ret);
        bit w; logic [1:0] b; int n; logic [23:0] fr; wr_t e; logic [2:0] ec;
        w = m_wide(); b = m_bank(); n = w ? 6 : 4;
        fr = {9'd0, w ? rpc : {1'b0, rpc[13:0]}};
        for (int i = n - 1; i >= 0; i--) begin
            sp_m = sp_m - 8'd1;
            e.a = {b, sp_m};
            e.d = fr[i*4 +: 4];
            wq.push_back(e);
        end
        pq.push_back(w ? tgt : {1'b0, tgt[13:0]});
        ptag.push_back("R6 call target load");
        rs_pc.push_back(fr[14:0]);
        ec = (lng ? 3'd3 : 3'd2) + (w ? 3'd1 : 3'd0);
        @(negedge clk);
        call_req = 1; call_long = lng; call_target = tgt; ret_pc = rpc; ret_req = with_ret;
        if (with_wr) begin dwr_en = 1; dwr_addr = 12'hF84; dwr_data = wd; end
        @(negedge clk);
        call_req = 0; ret_req = 0; dwr_en = 0;
        if (with_wr) cfg_m = {wd[3], 1'b0, wd[1:0]};
        chk(call_cycles == ec, lng ? "R8 long call cycles" : "R8 short call cycles",
            {29'd0, call_cycles}, {29'd0, ec});
        // requests while busy must be ignored
        call_req = 1; ret_req = 1;
        @(negedge clk);
        call_req = 0; ret_req = 0;
        wait_idle();
        chk(sp_value == sp_m, "R5 pointer after push", {24'd0, sp_value}, {24'd0, sp_m});
    endtask

    task automatic do_ret();
        bit w; int n; logic [14:0] v;
        w = m_wide(); n = w ? 6 : 4;
        v = rs_pc.pop_back();
        pq.push_back(w ? v : {1'b0, v[13:0]});
        ptag.push_back("R7 return address load");
        sp_m = sp_m + 8'(n);
        @(negedge clk);
        ret_req = 1;
        @(negedge clk);
        ret_req = 0;
        wait_idle();
        chk(sp_value == sp_m, "R7 pointer after pop", {24'd0, sp_value}, {24'd0, sp_m});
    endtask

    bit done = 0;
    initial begin
        #(20 * 150000);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cfg_m = 4'b1000; sp_m = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(stk_cfg == 4'b1000, "R1 reset cfg", {28'd0, stk_cfg}, 32'h8);
        chk(mode_wide == 0, "R1 reset mode", {31'd0, mode_wide}, 0);
        chk(sp_value == 0, "R1 reset pointer", {24'd0, sp_value}, 0);
        chk(busy == 0 && ram_we == 0, "R1 reset idle", {30'd0, busy, ram_we}, 0);

        // R9 in narrow mode
        @(negedge clk); rel_branch = 1;
        @(negedge clk); rel_branch = 0;
        chk(illegal_branch == 1, "R9 narrow illegal flag", {31'd0, illegal_branch}, 1);

        // narrow long call, target bit 14 dropped (R6), return bit 14 dropped (R5)
        do_call(15'h7ABC, 15'h5123, 1, 0, 4'h0, 0);
        // R2 bit 2 masked; R4 bank bits ignored in narrow
        wr_reg(12'hF84, 4'b1111);
        chk(stk_cfg == 4'b1011, "R2 bit2 reads zero", {28'd0, stk_cfg}, 32'hB);
        chk(mode_wide == 0, "R3 bit3 set is narrow", {31'd0, mode_wide}, 0);
        // short narrow call, call and return requested together (R10 call wins)
        do_call(15'h0456, 15'h0ABC, 0, 0, 4'h0, 1);
        do_ret();
        do_ret();
        // R2 other address ignored
        wr_reg(12'hF85, 4'b0000);
        chk(stk_cfg == 4'b1011, "R2 other address no effect", {28'd0, stk_cfg}, 32'hB);
        // wide mode, bank 2
        wr_reg(12'hF84, 4'b0110);
        chk(stk_cfg == 4'b0010, "R2 write wide bank2", {28'd0, stk_cfg}, 32'h2);
        chk(mode_wide == 1, "R3 bit3 clear is wide", {31'd0, mode_wide}, 1);
        @(negedge clk); rel_branch = 1;
        @(negedge clk); rel_branch = 0;
        chk(illegal_branch == 0, "R9 wide no flag", {31'd0, illegal_branch}, 0);
        do_call(15'h4321, 15'h6ABC, 1, 0, 4'h0, 0);
        do_call(15'h7F00, 15'h4001, 0, 0, 4'h0, 0);
        do_ret();
        // R11: write to narrow in the same cycle as a wide call
        do_call(15'h5555, 15'h7777, 1, 1, 4'b1000, 0);
        chk(mode_wide == 0, "R11 new mode after collision", {31'd0, mode_wide}, 0);
        chk(stk_cfg == 4'b1000, "R11 new cfg value", {28'd0, stk_cfg}, 32'h8);
        wr_reg(12'hF84, 4'b0010);
        do_ret();
        do_ret();
        repeat (3) @(negedge clk);
        chk(wq.size() == 0 && pq.size() == 0, "R10 scoreboard drained",
            wq.size() + pq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule